// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block sits between the status logic of a UART and its processor interface. It takes four interrupt sources: a receiver line-status error, received data (or a receive character timeout), an empty transmit holding register, and a modem-status change. It gates them with a 4-bit enable value and drives a single registered, active-high interrupt line. It also drives an 8-bit identification byte that names the highest-priority source still pending.

The received-data source comes from the receive FIFO fill count, compared against one of four programmable trigger thresholds. When FIFO mode is off, that comparison is replaced by a data-ready flag. Reading the identification byte while it reports the transmit-empty source clears that source. The source stays cleared until the holding register has been refilled and has become empty again.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `irq` is 0, `iid_rdata` is 8'h01 and `ier_rdata` is 8'h00.
- R2: The enable value is written with `ier_wr`. `ier_rdata[3:0]` returns the last value written, one cycle after the write, and `ier_rdata[7:4]` always reads 0. Enable bit 0 gates received data and timeout, bit 1 gates transmit-empty, bit 2 gates line status and bit 3 gates modem status.
- R3: `iid_rdata[0]` is an active-low pending flag. It is always the inverse of `irq`.
- R4: An enabled line-status error is reported with code `iid_rdata[3:1]` = 011, ahead of every other source.
- R5: Received data available reports code 010 and character timeout reports code 110. Both are at the second priority level, with received data ahead of timeout when both are pending.
- R6: Transmit-empty reports code 001 (third priority). Modem status reports code 000 (fourth priority). With no enabled source pending, the byte's low nibble is 0001.
- R7: In FIFO mode, received data is pending while `rx_count` is at or above the trigger level, and `data_ready` has no effect. The trigger level is selected by `fcr_trig`, which corresponds to FIFO-control bits [7:6]: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14.
- R8: With FIFO mode off, received data is pending exactly while `data_ready` is 1, and `rx_count` has no effect.
- R9: `iid_rdata[7:6]` reads 11 while FIFO mode is enabled and 00 otherwise. FIFO mode is enabled by `fcr_fifo` (FIFO-control bit 0), written with `fcr_wr`. `iid_rdata[5:4]` always reads 00.
- R10: A read strobe `iid_rd` taken while transmit-empty is the reported source suppresses that source. The suppression holds until `thr_empty` has gone low and then high again. A read strobe taken while a different source is reported does not suppress it.
- R11: A source whose enable bit is 0 is never reported and does not raise `irq`.
- R12: `irq` and the identification byte are registered. They reflect the source and enable inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_wr | input | 1 | Write strobe for the enable value |
| ier_wdata | input | 4 | Enable bits to write |
| ier_rdata | output | 8 | Enable value read-back |
| fcr_wr | input | 1 | Write strobe for FIFO control |
| fcr_fifo | input | 1 | FIFO mode enable (FIFO-control bit 0) |
| fcr_trig | input | 2 | Receive trigger select (FIFO-control bits [7:6]) |
| iid_rd | input | 1 | Read strobe of the identification byte |
| iid_rdata | output | 8 | Identification byte |
| lsr_err | input | 1 | Receiver line-status error pending |
| rx_count | input | CNT_W | Receive FIFO fill count |
| data_ready | input | 1 | Data-ready flag for non-FIFO mode |
| char_to | input | 1 | Receive character timeout |
| thr_empty | input | 1 | Transmit holding register empty |
| msr_delta | input | 1 | Modem-status change pending |
| irq | output | 1 | Registered interrupt, active high |

## Verification
The bench sweeps every combination of the five source conditions against all sixteen enable patterns. This exposes a swapped priority, for example timeout reported ahead of received data, and an enable bit wired to the wrong source, which would report a disabled source. It also runs every fill count across each of the four trigger selects. An off-by-one comparison, or a wrong threshold value, would move the first count that reports received data. In the transmit-empty read-clear test, one read is taken while the source is reported and one while a higher source masks it. A design that cleared on any read would lose the masked transmit-empty event, and one that never re-armed would stay silent after a refill.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

  typedef enum logic [2:0] {
    ID_MSR  = 3'b000,
    ID_THRE = 3'b001,
    ID_RDA  = 3'b010,
    ID_LSR  = 3'b011,
    ID_CTO  = 3'b110
  } irq_code_e;

  localparam int unsigned EN_W = 4;

  // Receive trigger threshold selected by the two-bit field.
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic level_met(input int unsigned cnt, input logic [1:0] sel);
    return cnt >= trig_level(sel);
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
  import uart_irq_pkg::*;
#(
  parameter bit HAS_FIFO = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ier_wr,
  input  logic [EN_W-1:0] ier_wdata,
  input  logic            fcr_wr,
  input  logic            fcr_fifo,
  input  logic [1:0]      fcr_trig,
  output logic [EN_W-1:0] en,
  output logic            fifo_en,
  output logic [1:0]      trig
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= '0;
    else if (ier_wr) en <= ier_wdata;
  end

  generate
    if (HAS_FIFO) begin : g_fifo
      logic       fifo_q;
      logic [1:0] trig_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fifo_q <= 1'b0;
          trig_q <= 2'b00;
        end else if (fcr_wr) begin
          fifo_q <= fcr_fifo;
          trig_q <= fcr_trig;
        end
      end
      assign fifo_en = fifo_q;
      assign trig    = trig_q;
    end else begin : g_nofifo
      assign fifo_en = 1'b0;
      assign trig    = 2'b00;
    end
  endgenerate

  // R2: a written enable value is held for the following cycle
  p_ier_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> (en == $past(ier_wdata)));

endmodule

// File: rtl/irq_rx_level.sv
`timescale 1ns/1ps
module irq_rx_level
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [1:0]       trig,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             data_ready,
  output logic             rda_cond
);

  logic count_hit;
  assign count_hit = level_met(32'(rx_count), trig);
  assign rda_cond  = fifo_en ? count_hit : data_ready;

  // R7: a count of fourteen or more meets every threshold in FIFO mode
  p_full_meets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && (32'(rx_count) >= 14)) |-> rda_cond);

  // R8: without FIFO mode an empty data-ready flag never yields received data
  p_nofifo_dr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !data_ready) |-> !rda_cond);

endmodule

// File: rtl/irq_thre_track.sv
`timescale 1ns/1ps
module irq_thre_track (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic iid_rd,
  input  logic thre_shown,
  output logic thre_src
);

  logic ack_q;

  // Acknowledge sticks until the holding register is refilled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ack_q <= 1'b0;
    else if (!thr_empty)          ack_q <= 1'b0;
    else if (iid_rd && thre_shown) ack_q <= 1'b1;
  end

  assign thre_src = thr_empty && !ack_q;

  // R10: reading the byte while transmit-empty is shown drops that source
  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_rd && thre_shown && thr_empty) |=> !thre_src);

  // R10: a refill re-arms the source once the register is empty again
  p_refill_rearms_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_empty |=> (thr_empty == thre_src));

endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EN_W-1:0] en,
  input  logic            lsr_err,
  input  logic            rda_cond,
  input  logic            char_to,
  input  logic            thre_src,
  input  logic            msr_delta,
  output logic [2:0]      code_q,
  output logic            pend_n_q,
  output logic            irq_q
);

  logic req_lsr, req_rda, req_cto, req_thre, req_msr, any_req;
  irq_code_e code_d;

  assign req_lsr  = en[2] && lsr_err;
  assign req_rda  = en[0] && rda_cond;
  assign req_cto  = en[0] && char_to;
  assign req_thre = en[1] && thre_src;
  assign req_msr  = en[3] && msr_delta;
  assign any_req  = req_lsr || req_rda || req_cto || req_thre || req_msr;

  always_comb begin
    if      (req_lsr)  code_d = ID_LSR;
    else if (req_rda)  code_d = ID_RDA;
    else if (req_cto)  code_d = ID_CTO;
    else if (req_thre) code_d = ID_THRE;
    else               code_d = ID_MSR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= 3'b000;
      pend_n_q <= 1'b1;
      irq_q    <= 1'b0;
    end else begin
      code_q   <= code_d;
      pend_n_q <= !any_req;
      irq_q    <= any_req;
    end
  end

  // R4: an enabled line-status error always wins
  p_lsr_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_lsr |=> (code_q == ID_LSR));

  // R5: received data outranks the timeout at the shared level
  p_rda_over_cto_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rda && !req_lsr) |=> (code_q == ID_RDA));

  // R12: the interrupt line follows requests one edge later
  p_irq_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> irq_q);

  // R11: nothing enabled and pending keeps the line low
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> !irq_q);

endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W    = 5,
  parameter bit          HAS_FIFO = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [3:0]       ier_wdata,
  output logic [7:0]       ier_rdata,
  input  logic             fcr_wr,
  input  logic             fcr_fifo,
  input  logic [1:0]       fcr_trig,
  input  logic             iid_rd,
  output logic [7:0]       iid_rdata,
  input  logic             lsr_err,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             data_ready,
  input  logic             char_to,
  input  logic             thr_empty,
  input  logic             msr_delta,
  output logic             irq
);

  logic [EN_W-1:0] en;
  logic            fifo_en;
  logic [1:0]      trig;
  logic            rda_cond;
  logic            thre_src;
  logic            thre_shown;
  logic [2:0]      code_q;
  logic            pend_n_q;

  irq_cfg_regs #(.HAS_FIFO(HAS_FIFO)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .fcr_wr(fcr_wr), .fcr_fifo(fcr_fifo), .fcr_trig(fcr_trig),
    .en(en), .fifo_en(fifo_en), .trig(trig)
  );

  irq_rx_level #(.CNT_W(CNT_W)) u_lvl (
    .clk(clk), .rst_n(rst_n),
    .fifo_en(fifo_en), .trig(trig), .rx_count(rx_count),
    .data_ready(data_ready), .rda_cond(rda_cond)
  );

  assign thre_shown = (code_q == ID_THRE) && !pend_n_q;

  irq_thre_track u_thre (
    .clk(clk), .rst_n(rst_n),
    .thr_empty(thr_empty), .iid_rd(iid_rd),
    .thre_shown(thre_shown), .thre_src(thre_src)
  );

  irq_prio_enc u_enc (
    .clk(clk), .rst_n(rst_n), .en(en),
    .lsr_err(lsr_err), .rda_cond(rda_cond), .char_to(char_to),
    .thre_src(thre_src), .msr_delta(msr_delta),
    .code_q(code_q), .pend_n_q(pend_n_q), .irq_q(irq)
  );

  assign ier_rdata = {4'b0000, en};
  assign iid_rdata = {{2{fifo_en}}, 2'b00, code_q, pend_n_q};

  // R3: the pending flag in the byte is the inverse of the line
  p_pend_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iid_rdata[0] == !irq);

  // R9: the FIFO indication bits track the configured mode
  p_fifo_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fcr_wr) |-> (iid_rdata[7:6] == {2{$past(fcr_fifo) && HAS_FIFO}}));

endmodule

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;

  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_wr = 0, fcr_wr = 0, fcr_fifo = 0, iid_rd = 0;
  logic [3:0] ier_wdata = '0;
  logic [1:0] fcr_trig = '0;
  logic lsr_err = 0, data_ready = 0, char_to = 0, thr_empty = 0, msr_delta = 0;
  logic [CW-1:0] rx_count = '0;
  logic [7:0] ier_rdata, iid_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_irq_ident #(.CNT_W(CW), .HAS_FIFO(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_rdata(ier_rdata),
    .fcr_wr(fcr_wr), .fcr_fifo(fcr_fifo), .fcr_trig(fcr_trig),
    .iid_rd(iid_rd), .iid_rdata(iid_rdata),
    .lsr_err(lsr_err), .rx_count(rx_count), .data_ready(data_ready),
    .char_to(char_to), .thr_empty(thr_empty), .msr_delta(msr_delta),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ier(input logic [3:0] v);
    ier_wdata = v; ier_wr = 1; step(1); ier_wr = 0;
  endtask

  task automatic set_fcr(input logic f, input logic [1:0] t);
    fcr_fifo = f; fcr_trig = t; fcr_wr = 1; step(1); fcr_wr = 0;
  endtask

  // Expected byte: later lines overwrite earlier ones, so the last matching
  // line is the most urgent source.
  function automatic logic [7:0] model(input logic [3:0] e, input logic f,
    input logic ls, input logic rd, input logic to, input logic th, input logic ms);
    logic [3:0] lo = 4'h1;
    if (e[3] && ms) lo = 4'h0;
    if (e[1] && th) lo = 4'h2;
    if (e[0] && to) lo = 4'hC;
    if (e[0] && rd) lo = 4'h4;
    if (e[2] && ls) lo = 4'h6;
    return {f ? 2'b11 : 2'b00, 2'b00, lo};
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1: reset values
    check("R1 iid", iid_rdata, 8'h01);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 ier", ier_rdata, 8'h00);
    rst_n = 1; step(2);

    // R2: read-back, upper bits zero
    set_ier(4'hF); step(1);
    check("R2 ier all", ier_rdata, 8'h0F);
    set_ier(4'h5); step(1);
    check("R2 ier 5", ier_rdata, 8'h05);

    // R4 R5 R6 R11 R3 R8: full sweep, FIFO off, count ignored
    rx_count = 5'd16;
    for (int e = 0; e < 16; e++) begin
      set_ier(4'(e));
      for (int s = 0; s < 32; s++) begin
        {lsr_err, data_ready, char_to, thr_empty, msr_delta} = 5'(s);
        step(2);
        check("R4/R5/R6/R11/R8 id", iid_rdata,
              model(4'(e), 1'b0, s[4], s[3], s[2], s[1], s[0]));
        check("R3 pend", {7'b0, iid_rdata[0]}, {7'b0, ~irq});
      end
    end
    {lsr_err, data_ready, char_to, thr_empty, msr_delta} = '0;

    // R7 R9: trigger thresholds in FIFO mode, data_ready held opposite
    set_ier(4'h1);
    for (int t = 0; t < 4; t++) begin
      int lvl;
      set_fcr(1'b1, 2'(t));
      lvl = (t == 0) ? 1 : (t == 3) ? 14 : (4 << (t - 1));
      for (int c = 0; c <= 16; c++) begin
        rx_count = 5'(c);
        data_ready = (c < lvl);
        step(2);
        check("R7/R9 trig", iid_rdata, (c >= lvl) ? 8'hC4 : 8'hC1);
      end
    end
    rx_count = '0; data_ready = 0;
    set_fcr(1'b0, 2'b00); step(1);
    check("R9 fifo off", iid_rdata, 8'h01);

    // R12: registered output
    set_ier(4'h4); step(1);
    lsr_err = 1; #1;
    check("R12 before edge", {7'b0, irq}, 8'h00);
    step(1);
    check("R12 after edge", {7'b0, irq}, 8'h01);
    check("R4 lsr code", iid_rdata, 8'h06);
    lsr_err = 0;

    // R10: read clears transmit-empty until refill
    set_ier(4'h2); thr_empty = 1; step(2);
    check("R10 shown", iid_rdata, 8'h02);
    iid_rd = 1; step(1); iid_rd = 0; step(1);
    check("R10 cleared", iid_rdata, 8'h01);
    step(3);
    check("R10 stays clear", iid_rdata, 8'h01);
    thr_empty = 0; step(2);
    thr_empty = 1; step(2);
    check("R10 re-armed", iid_rdata, 8'h02);

    // R10: read while line status masks it leaves transmit-empty pending
    set_ier(4'h6); lsr_err = 1; step(2);
    check("R10 masked shown", iid_rdata, 8'h06);
    iid_rd = 1; step(1); iid_rd = 0;
    lsr_err = 0; step(2);
    check("R10 masked kept", iid_rdata, 8'h02);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule